// File: doc/BRIEF.md
# Speculative Transaction Nesting Depth Tracker

This block lives beside the load-queue insertion point of an out-of-order core. As memory operations are dispatched in program order, it counts transaction-begin and transaction-end markers. Each dispatched operation receives a tag: a transactional bit, the identifier of the enclosing transaction, and the current nesting depth. The tag is derived from the difference between the begin and end counts.

Dispatch can run ahead of commit, so the counts are speculative. When the pipeline flushes, the youngest queued operations are removed one per cycle. Each removal walks the matching counter back, and no counter drops below zero. Once the flush is signalled complete, the local identifier register is rebuilt. It takes the identifier of the youngest begin marker still queued. If no such marker remains, or its identifier is zero, it takes the identifier last retired by commit.

The queued operations are kept in a small ring of flag and identifier entries. Commit removes the oldest entry. An abort clears both counters.

Insertion uses valid/ready. An operation is taken only in a cycle where both `ins_valid` and `ins_ready` are high. While `ins_ready` is low, the source must hold the operation. The tag output has no back-pressure: it is a one-cycle valid pulse. All other pins are plain strobes or levels.

Top module: `txn_depth_tracker`

## Requirements
- R1: An insert is accepted when `ins_valid` and `ins_ready` are both high. `ins_ready` is low in any of these cases: the ring holds DEPTH entries, `sq_pop` is high, `abort_clr` is high, or it is the cycle after `sq_done` was high. An accepted insert raises `tag_valid` for exactly the next cycle.
- R2: An accepted insert with `ins_start`=1 raises `start_cnt` by one. If `start_cnt` <= `stop_cnt` just before the insert, `local_uid` increments and the begin marker carries the new value. Otherwise the begin marker reuses `local_uid`. When `ins_start` and `ins_stop` are both 1, the insert is a begin marker only and `stop_cnt` does not change.
- R3: An accepted insert with `ins_stop`=1 and `ins_start`=0 raises `stop_cnt` by one.
- R4: The tag is judged after the insert's own counter update. If start count > stop count, then `tag_txn`=1, `tag_uid` is the begin marker's identifier (or `local_uid` for other operations), and `tag_depth` is the start count minus the stop count. Otherwise `tag_txn`=0, `tag_uid`=0 and `tag_depth`=0.
- R5: `sq_pop` on a non-empty ring removes the youngest entry. Removing a begin entry lowers `start_cnt` by one, and removing an end entry lowers `stop_cnt` by one. A counter already at zero stays at zero. A plain entry, or an empty ring, leaves both counters unchanged.
- R6: Let `sq_done` be high at clock edge k. During the following cycle, the ring is scanned from oldest to youngest and the last begin entry found supplies an identifier. After edge k+1, `local_uid` holds that identifier if it is nonzero, and otherwise the stored last-retired identifier.
- R7: A `ret_wr` pulse whose `ret_uid` is not below the stored last-retired identifier replaces it. A lower `ret_uid` leaves the stored value unchanged and sets `uid_err`, which stays high until reset.
- R8: `abort_clr` clears `start_cnt` and `stop_cnt` at the next edge. This takes priority over any insert or squash in the same cycle. `abort_clr` does not change the ring or `local_uid`.
- R9: `ret_pop` removes the oldest entry when the ring is non-empty and `sq_pop` is low. It is ignored while `sq_pop` is high.
- R10: After reset: both counters are 0, `local_uid` is 0, the ring is empty, `tag_valid` and `uid_err` are 0, and the stored last-retired identifier is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Dispatch offers an operation |
| ins_ready | output | 1 | Tracker can accept the operation |
| ins_start | input | 1 | Operation begins a transaction |
| ins_stop | input | 1 | Operation ends a transaction |
| sq_pop | input | 1 | Remove the youngest queued entry |
| sq_done | input | 1 | Flush finished; repair identifier next cycle |
| ret_pop | input | 1 | Commit removes the oldest entry |
| ret_wr | input | 1 | Commit reports a retired identifier |
| ret_uid | input | UID_W | Retired identifier value |
| abort_clr | input | 1 | Transaction abort: clear both counters |
| tag_valid | output | 1 | Tag for the last accepted operation |
| tag_txn | output | 1 | Operation is inside a transaction |
| tag_uid | output | UID_W | Transaction identifier of the operation |
| tag_depth | output | CNT_W | Nesting depth of the operation |
| local_uid | output | UID_W | Current local transaction identifier |
| start_cnt | output | CNT_W | Speculative begin count |
| stop_cnt | output | CNT_W | Speculative end count |
| uid_err | output | 1 | Sticky flag: retired identifier went backwards |

## Verification
Timing of each result, relative to the clock edge that samples a stimulus:
- `ins_ready` is combinational. It is checked in the same cycle, one time step after the inputs are driven.
- Tags, both counters, `local_uid` for an allocation, and `uid_err` appear after that edge. They are checked one time step after it.
- The identifier repair appears only after the second edge following `sq_done`. Its check waits for that edge, and the model carries a pending-repair flag across the intervening cycle.

Directed sequences cover nesting, fill to full, flush with and without a surviving begin marker, retired-identifier regressions and aborts. These are followed by a long pseudo-random sweep of mixed operations. Throughout, a queue model in the bench recomputes every expected value arithmetically.

// File: rtl/txn_depth_pkg.sv
package txn_depth_pkg;
  typedef struct packed {
    logic is_begin;
    logic is_end;
  } txn_kind_t;

  typedef enum logic [1:0] {
    CNT_HOLD = 2'd0,
    CNT_INC  = 2'd1,
    CNT_DEC  = 2'd2,
    CNT_CLR  = 2'd3
  } cnt_op_e;
endpackage

// File: rtl/txn_sat_counter.sv
module txn_sat_counter
  import txn_depth_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  cnt_op_e      op,
  output logic [W-1:0] val
);
  localparam logic [W-1:0] MAXV = '1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      val <= '0;
    end else begin
      case (op)
        CNT_INC: if (val != MAXV) val <= val + 1'b1;
        CNT_DEC: if (val != '0)   val <= val - 1'b1;
        CNT_CLR: val <= '0;
        default: val <= val;
      endcase
    end
  end
endmodule

// File: rtl/txn_ring.sv
module txn_ring
  import txn_depth_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int UID_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  txn_kind_t        push_kind,
  input  logic [UID_W-1:0] push_uid,
  input  logic             pop_young,
  input  logic             pop_old,
  output logic             full,
  output logic             empty,
  output txn_kind_t        young_kind,
  output logic [UID_W-1:0] scan_uid
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [AW-1:0]    head;
  logic [AW:0]      cnt;
  txn_kind_t        kind_q [DEPTH];
  logic [UID_W-1:0] uid_q  [DEPTH];
  logic [AW-1:0]    tail, young;
  logic             do_py, do_po;

  assign tail  = head + cnt[AW-1:0];
  assign young = tail - AW'(1);
  assign empty = (cnt == '0);
  assign full  = (cnt == (AW+1)'(DEPTH));
  assign do_py = pop_young && !empty;
  assign do_po = pop_old && !pop_young && !empty;
  assign young_kind = empty ? txn_kind_t'('0) : kind_q[young];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head <= '0;
      cnt  <= '0;
    end else begin
      if (do_po) head <= head + AW'(1);
      case ({push, do_py || do_po})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      kind_q[tail] <= push_kind;
      uid_q[tail]  <= push_uid;
    end
  end

  // oldest-to-youngest walk; the youngest begin entry wins
  always_comb begin
    logic [AW-1:0] idx;
    scan_uid = '0;
    for (int i = 0; i < DEPTH; i++) begin
      idx = head + AW'(i);
      if (((AW+1)'(i) < cnt) && kind_q[idx].is_begin) scan_uid = uid_q[idx];
    end
  end
endmodule

// File: rtl/txn_uid_unit.sv
module txn_uid_unit #(
  parameter int UID_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc,
  input  logic             repair,
  input  logic [UID_W-1:0] scan_uid,
  input  logic             ret_wr,
  input  logic [UID_W-1:0] ret_uid,
  output logic [UID_W-1:0] local_uid,
  output logic             uid_err
);
  logic [UID_W-1:0] last_ret;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      local_uid <= '0;
      last_ret  <= '0;
      uid_err   <= 1'b0;
    end else begin
      if (repair)     local_uid <= (scan_uid != '0) ? scan_uid : last_ret;
      else if (alloc) local_uid <= local_uid + 1'b1;
      if (ret_wr) begin
        if (ret_uid < last_ret) uid_err  <= 1'b1;
        else                    last_ret <= ret_uid;
      end
    end
  end
endmodule

// File: rtl/txn_depth_tracker.sv
module txn_depth_tracker
  import txn_depth_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int UID_W = 16,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ins_valid,
  output logic             ins_ready,
  input  logic             ins_start,
  input  logic             ins_stop,
  input  logic             sq_pop,
  input  logic             sq_done,
  input  logic             ret_pop,
  input  logic             ret_wr,
  input  logic [UID_W-1:0] ret_uid,
  input  logic             abort_clr,
  output logic             tag_valid,
  output logic             tag_txn,
  output logic [UID_W-1:0] tag_uid,
  output logic [CNT_W-1:0] tag_depth,
  output logic [UID_W-1:0] local_uid,
  output logic [CNT_W-1:0] start_cnt,
  output logic [CNT_W-1:0] stop_cnt,
  output logic             uid_err
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  logic             full, empty, rep_q, acc, in_txn, alloc, sq_eff;
  logic             end_only, after_txn;
  txn_kind_t        young_kind, push_kind;
  logic [UID_W-1:0] scan_uid, new_uid;
  logic [CNT_W-1:0] start_after, stop_after;
  cnt_op_e          begin_op, end_op;

  assign ins_ready = !full && !sq_pop && !rep_q && !abort_clr;
  assign acc       = ins_valid && ins_ready;
  assign end_only  = ins_stop && !ins_start;
  assign in_txn    = start_cnt > stop_cnt;
  assign alloc     = acc && ins_start && !in_txn;
  assign new_uid   = alloc ? local_uid + 1'b1 : local_uid;
  assign sq_eff    = sq_pop && !empty;

  assign start_after = (ins_start && start_cnt != CMAX) ? start_cnt + 1'b1 : start_cnt;
  assign stop_after  = (end_only && stop_cnt != CMAX) ? stop_cnt + 1'b1 : stop_cnt;
  assign after_txn   = start_after > stop_after;

  assign push_kind.is_begin = ins_start;
  assign push_kind.is_end   = end_only;

  always_comb begin
    begin_op = CNT_HOLD;
    if (abort_clr)                            begin_op = CNT_CLR;
    else if (sq_eff && young_kind.is_begin)   begin_op = CNT_DEC;
    else if (acc && ins_start)                begin_op = CNT_INC;
  end

  always_comb begin
    end_op = CNT_HOLD;
    if (abort_clr)                            end_op = CNT_CLR;
    else if (sq_eff && young_kind.is_end)     end_op = CNT_DEC;
    else if (acc && end_only)                 end_op = CNT_INC;
  end

  txn_sat_counter #(.W(CNT_W)) u_begin_cnt (
    .clk(clk), .rst_n(rst_n), .op(begin_op), .val(start_cnt)
  );

  txn_sat_counter #(.W(CNT_W)) u_end_cnt (
    .clk(clk), .rst_n(rst_n), .op(end_op), .val(stop_cnt)
  );

  txn_ring #(.DEPTH(DEPTH), .UID_W(UID_W)) u_ring (
    .clk(clk), .rst_n(rst_n),
    .push(acc), .push_kind(push_kind),
    .push_uid(ins_start ? new_uid : '0),
    .pop_young(sq_pop), .pop_old(ret_pop),
    .full(full), .empty(empty),
    .young_kind(young_kind), .scan_uid(scan_uid)
  );

  txn_uid_unit #(.UID_W(UID_W)) u_uid (
    .clk(clk), .rst_n(rst_n),
    .alloc(alloc), .repair(rep_q), .scan_uid(scan_uid),
    .ret_wr(ret_wr), .ret_uid(ret_uid),
    .local_uid(local_uid), .uid_err(uid_err)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rep_q     <= 1'b0;
      tag_valid <= 1'b0;
      tag_txn   <= 1'b0;
      tag_uid   <= '0;
      tag_depth <= '0;
    end else begin
      rep_q     <= sq_done;
      tag_valid <= acc;
      if (acc) begin
        tag_txn   <= after_txn;
        tag_uid   <= after_txn ? new_uid : '0;
        tag_depth <= after_txn ? start_after - stop_after : '0;
      end
    end
  end
endmodule

// File: rtl/txn_depth_tracker_chk.sv
module txn_depth_tracker_chk #(
  parameter int UID_W = 16,
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ins_valid,
  input logic             ins_ready,
  input logic             ins_start,
  input logic             sq_pop,
  input logic             abort_clr,
  input logic             tag_valid,
  input logic             tag_txn,
  input logic [UID_W-1:0] tag_uid,
  input logic [CNT_W-1:0] tag_depth,
  input logic [CNT_W-1:0] start_cnt,
  input logic [CNT_W-1:0] stop_cnt,
  input logic             uid_err
);
  AST_BLOCK_ON_SQUASH: assert property (@(posedge clk) disable iff (!rst_n)
    sq_pop |-> !ins_ready); // R1
  AST_BEGIN_HOLDS_END: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && ins_ready && ins_start && !sq_pop) |=> $stable(stop_cnt)); // R2
  AST_NOTXN_TAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (tag_valid && !tag_txn) |-> (tag_uid == '0 && tag_depth == '0)); // R4
  AST_TXN_TAG_DEPTH: assert property (@(posedge clk) disable iff (!rst_n)
    (tag_valid && tag_txn) |-> (tag_depth != '0)); // R4
  AST_SQUASH_NO_GROW: assert property (@(posedge clk) disable iff (!rst_n)
    sq_pop |=> (start_cnt <= $past(start_cnt) && stop_cnt <= $past(stop_cnt))); // R5
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    uid_err |=> uid_err); // R7
  AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    abort_clr |=> (start_cnt == '0 && stop_cnt == '0)); // R8
endmodule

bind txn_depth_tracker txn_depth_tracker_chk #(.UID_W(UID_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_ready(ins_ready),
  .ins_start(ins_start), .sq_pop(sq_pop), .abort_clr(abort_clr),
  .tag_valid(tag_valid), .tag_txn(tag_txn), .tag_uid(tag_uid),
  .tag_depth(tag_depth), .start_cnt(start_cnt), .stop_cnt(stop_cnt),
  .uid_err(uid_err)
);

// File: tb/txn_depth_tracker_bench.sv
module txn_depth_tracker_bench;
  localparam int DEPTH = 8;
  localparam int UID_W = 16;
  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ins_valid = 0, ins_start = 0, ins_stop = 0, sq_pop = 0, sq_done = 0;
  logic ret_pop = 0, ret_wr = 0, abort_clr = 0;
  logic [UID_W-1:0] ret_uid = '0;
  logic ins_ready, tag_valid, tag_txn, uid_err;
  logic [UID_W-1:0] tag_uid, local_uid;
  logic [CNT_W-1:0] tag_depth, start_cnt, stop_cnt;

  always #5 clk = ~clk;

  txn_depth_tracker #(.DEPTH(DEPTH), .UID_W(UID_W), .CNT_W(CNT_W)) u_txn_depth_tracker (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_ready(ins_ready),
    .ins_start(ins_start), .ins_stop(ins_stop), .sq_pop(sq_pop), .sq_done(sq_done),
    .ret_pop(ret_pop), .ret_wr(ret_wr), .ret_uid(ret_uid), .abort_clr(abort_clr),
    .tag_valid(tag_valid), .tag_txn(tag_txn), .tag_uid(tag_uid), .tag_depth(tag_depth),
    .local_uid(local_uid), .start_cnt(start_cnt), .stop_cnt(stop_cnt), .uid_err(uid_err)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  // reference model: queue kept oldest-first
  bit       m_b [DEPTH];
  bit       m_e [DEPTH];
  int       m_u [DEPTH];
  int       mcnt = 0, ms = 0, mt = 0, luid = 0, lr = 0;
  bit       merr = 0, mrep = 0, m_retpop = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(input bit iv, input bit is, input bit ip, input bit sp, input bit sd,
                      input bit ab, input bit rp, input bit rw, input int ru);
    bit rdy, acc, in_now, alloc, tv, ttx;
    int ns, nt, uidn, sc, nl, ms2, mt2, tu, td;
    string clbl;
    ins_valid = iv; ins_start = is; ins_stop = ip; sq_pop = sp; sq_done = sd;
    abort_clr = ab; ret_pop = rp; ret_wr = rw; ret_uid = UID_W'(ru);
    #1;
    rdy = (mcnt < DEPTH) && !sp && !mrep && !ab;
    chk(ins_ready == rdy, m_retpop ? "R9" : "R1", "ins_ready", ins_ready, rdy);
    acc = iv && rdy;
    in_now = ms > mt;
    ns = (is && ms != 255) ? ms + 1 : ms;
    nt = (ip && !is && mt != 255) ? mt + 1 : mt;
    alloc = acc && is && !in_now;
    uidn = alloc ? (luid + 1) % 65536 : luid;
    sc = 0;
    for (int i = 0; i < mcnt; i++) if (m_b[i]) sc = m_u[i];
    nl = mrep ? ((sc != 0) ? sc : lr) : uidn;
    ms2 = ms; mt2 = mt; clbl = "R1";
    if (ab) begin ms2 = 0; mt2 = 0; clbl = "R8"; end
    else if (sp && mcnt > 0) begin
      if (m_b[mcnt-1] && ms > 0) ms2 = ms - 1;
      if (m_e[mcnt-1] && mt > 0) mt2 = mt - 1;
      clbl = "R5";
    end else if (acc) begin
      ms2 = ns; mt2 = nt; clbl = is ? "R2" : (ip ? "R3" : "R1");
    end
    m_retpop = 0;
    if (sp) begin
      if (mcnt > 0) mcnt--;
    end else begin
      if (rp && mcnt > 0) begin
        for (int i = 0; i < DEPTH - 1; i++) begin
          m_b[i] = m_b[i+1]; m_e[i] = m_e[i+1]; m_u[i] = m_u[i+1];
        end
        mcnt--; m_retpop = 1;
      end
      if (acc) begin
        m_b[mcnt] = is; m_e[mcnt] = ip && !is; m_u[mcnt] = is ? uidn : 0; mcnt++;
      end
    end
    if (rw) begin
      if (ru < lr) merr = 1; else lr = ru;
    end
    tv = acc; ttx = ns > nt;
    tu = ttx ? uidn : 0; td = ttx ? ns - nt : 0;
    mrep = sd; ms = ms2; mt = mt2;
    @(posedge clk); #1;
    chk(start_cnt == CNT_W'(ms), clbl, "start_cnt", start_cnt, ms);
    chk(stop_cnt == CNT_W'(mt), clbl, "stop_cnt", stop_cnt, mt);
    chk(local_uid == UID_W'(nl), (nl != luid || alloc) && !alloc ? "R6" : "R2", "local_uid", local_uid, nl);
    luid = nl;
    chk(uid_err == merr, "R7", "uid_err", uid_err, merr);
    chk(tag_valid == tv, "R1", "tag_valid", tag_valid, tv);
    if (tv) begin
      chk(tag_txn == ttx, "R4", "tag_txn", tag_txn, ttx);
      chk(tag_uid == UID_W'(tu), "R4", "tag_uid", tag_uid, tu);
      chk(tag_depth == CNT_W'(td), "R4", "tag_depth", tag_depth, td);
    end
    @(negedge clk);
  endtask

  task automatic ins(input bit is, input bit ip);
    step(1, is, ip, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(start_cnt == 0, "R10", "start_cnt", start_cnt, 0);
    chk(stop_cnt == 0, "R10", "stop_cnt", stop_cnt, 0);
    chk(local_uid == 0, "R10", "local_uid", local_uid, 0);
    chk(tag_valid == 0, "R10", "tag_valid", tag_valid, 0);
    chk(uid_err == 0, "R10", "uid_err", uid_err, 0);
    chk(ins_ready == 1, "R10", "ins_ready", ins_ready, 1);
    @(negedge clk);
    // nesting: plain, begin, begin, plain, end, end, plain, begin
    ins(0, 0); ins(1, 0); ins(1, 0); ins(0, 0);
    ins(0, 1); ins(0, 1); ins(0, 0); ins(1, 1);
    // ring full: insert refused
    ins(0, 0); idle();
    // retire two, reinsert
    step(0, 0, 0, 0, 0, 0, 1, 0, 0); step(1, 0, 1, 0, 0, 0, 1, 0, 0);
    // flush four youngest then repair
    for (int i = 0; i < 4; i++) step(0, 0, 0, 1, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1, 0, 0, 0, 0); idle(); idle();
    // retired identifier updates and a regression
    step(0, 0, 0, 0, 0, 0, 0, 1, 5); step(0, 0, 0, 0, 0, 0, 0, 1, 3);
    // flush everything, repair falls back to retired identifier
    for (int i = 0; i < 9; i++) step(0, 0, 0, 1, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1, 0, 0, 0, 0); idle();
    // squash at zero counts, abort
    ins(0, 1); step(0, 0, 0, 1, 0, 0, 0, 0, 0);
    ins(1, 0); ins(1, 0); step(1, 0, 0, 0, 0, 1, 0, 0, 0); idle();
    // pseudo-random sweep
    for (int n = 0; n < 6000; n++) begin
      int r, q;
      r = $urandom % 16;
      q = $urandom % 10;
      if (r < 8)
        step(1, q < 3, q >= 3 && q < 6, 0, 0, 0, ($urandom % 4) == 0, 0, 0);
      else if (r < 11) step(0, 0, 0, 1, 0, 0, q == 0, 0, 0);
      else if (r == 11) step(0, 0, 0, 0, 1, 0, 0, 0, 0);
      else if (r == 12) step(q < 4, 1, 0, 0, 0, q < 2, 0, 0, 0);
      else if (r == 13) step(0, 0, 0, 0, 0, 0, 1, 1, (q == 0) ? lr - 1 : lr + q);
      else idle();
    end
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule